// File: doc/BRIEF.md
# Qualified Command/Address Register for a Memory Module

This block sits between a memory controller and the DRAM devices on a registered module. On every rising clock edge it samples the command/address bus, the chip-select inputs, the clock-enable and on-die-termination bits and a parity bit. The command/address word and the chip selects are forwarded only when exactly one chip select is active. Otherwise the chip-select outputs return to idle (high) and the command/address outputs keep their last value. Clock-enable and termination bits are not tied to a command, so they are re-driven on every edge.

A static strap input sets how chip selects fan out. With the strap high there are two selects, and each drives an A-side copy and a B-side copy. With the strap low there are four selects, and each drives exactly one output. An internal four-bit enable register, loaded from a plain write strobe, can park whole output groups at their idle level so that unused loads draw no switching power. A mismatch on even parity over the bus and the parity bit is reported through an active-low error pin. The report comes a cycle later and only when that bus transfer was qualified.

The bus is a register stage with no back-pressure. The controller presents one transfer per clock, and the block has no ready signal. A transfer is accepted on every edge, and whether it reaches the command/address outputs depends only on the chip-select qualification. The data interface therefore has no valid/ready pair, and all pins are plain.

Top module: `rcd_ca_register`

## Requirements
- R1: Inputs are sampled on the rising clock edge, and the corresponding outputs change after that same edge (one register stage).
- R2: With `quad_sel_n` = 1 (dual mode), only `cs_n_i[1:0]` are examined. `qcs_n_o[0]` and `qcs_n_o[2]` carry select 0, `qcs_n_o[1]` and `qcs_n_o[3]` carry select 1, and `cs_n_i[3:2]` have no effect.
- R3: With `quad_sel_n` = 0 (quad mode), `qcs_n_o[k]` carries `cs_n_i[k]` for k = 0..3.
- R4: When the examined selects have exactly one low bit, `ca_i` is loaded into the command/address outputs and the mapped selects are driven. With zero or several low bits, `qcs_n_o` goes to all ones and the command/address outputs hold their previous value.
- R5: `cke_i` and `odt_i` are copied to both sides on every edge, whatever the chip-select state.
- R6: A write strobe `cfg_we` loads `cfg_wdata` into the enable register, which takes effect from that edge. Bit 0 enables A-side command/address, bit 1 B-side command/address, bit 2 A-side CKE/ODT and bit 3 B-side CKE/ODT. A cleared bit forces its group to all zeros, and chip selects are unaffected.
- R7: A parity error is a qualified transfer for which the XOR of `ca_i` and `par_i` is 1. For an error sampled on edge k, `err_n_o` is low after edges k+1 and k+2 and high again after k+3, unless a new error extends it. Unqualified transfers never flag.
- R8: Reset is synchronous and active low. It forces `qcs_n_o` high, CKE/ODT low, command/address to zero and `err_n_o` high, and it sets all enable bits to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| quad_sel_n | input | 1 | Strap: 1 = dual select mode, 0 = quad select mode |
| cs_n_i | input | 4 | Active-low chip-select inputs |
| ca_i | input | CA_W | Command/address bus |
| cke_i | input | CTRL_W | Clock-enable bits |
| odt_i | input | CTRL_W | On-die-termination bits |
| par_i | input | 1 | Even-parity bit over `ca_i` |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 4 | Enable register write value |
| qa_ca_o | output | CA_W | A-side command/address copy |
| qb_ca_o | output | CA_W | B-side command/address copy |
| qcs_n_o | output | 4 | Active-low chip-select outputs |
| qa_cke_o | output | CTRL_W | A-side clock-enable copy |
| qb_cke_o | output | CTRL_W | B-side clock-enable copy |
| qa_odt_o | output | CTRL_W | A-side termination copy |
| qb_odt_o | output | CTRL_W | B-side termination copy |
| err_n_o | output | 1 | Active-low parity error flag |

## Verification
The bench builds the block with `CA_W` = 12, `CTRL_W` = 2 and `ERR_CYC` = 2. The narrow bus lets chosen words of odd and even weight hit the parity path on purpose, while random words still cover many bit combinations. The two-cycle error window is short enough that back-to-back errors and the extension of a running window both occur within a few transfers. At this width every select pattern in both strap settings is driven, including the upper selects that dual mode must ignore.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int NCS  = 4;
  localparam int OE_W = 4;

  localparam int OE_CA_A = 0;
  localparam int OE_CA_B = 1;
  localparam int OE_CT_A = 2;
  localparam int OE_CT_B = 3;

  typedef enum logic {
    CS_QUAD = 1'b0,
    CS_DUAL = 1'b1
  } cs_mode_e;

  function automatic logic [NCS-1:0] fold_selects(input cs_mode_e mode,
                                                  input logic [NCS-1:0] raw_n);
    if (mode == CS_DUAL) return {2'b11, raw_n[1:0]};
    return raw_n;
  endfunction

  function automatic logic [NCS-1:0] fan_selects(input cs_mode_e mode,
                                                 input logic [NCS-1:0] raw_n);
    if (mode == CS_DUAL) return {raw_n[1:0], raw_n[1:0]};
    return raw_n;
  endfunction
endpackage

// File: rtl/rcd_cs_qual.sv
module rcd_cs_qual
  import rcd_pkg::*;
(
  input  logic           mode_dual,
  input  logic [NCS-1:0] cs_n,
  output logic           sel_one,
  output logic [NCS-1:0] cs_fan_n
);
  cs_mode_e       mode;
  logic [NCS-1:0] seen_n;
  logic [$clog2(NCS+1)-1:0] low_cnt;

  always_comb begin
    mode   = mode_dual ? CS_DUAL : CS_QUAD;
    seen_n = fold_selects(mode, cs_n);
    low_cnt = '0;
    for (int i = 0; i < NCS; i++) begin
      if (!seen_n[i]) low_cnt = low_cnt + 1'b1;
    end
    sel_one  = (low_cnt == 1);
    cs_fan_n = fan_selects(mode, cs_n);
  end
endmodule

// File: rtl/rcd_capture.sv
module rcd_capture
  import rcd_pkg::*;
#(
  parameter int CA_W   = 22,
  parameter int CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_one,
  input  logic [NCS-1:0]    cs_fan_n,
  input  logic [CA_W-1:0]   ca_d,
  input  logic [CTRL_W-1:0] cke_d,
  input  logic [CTRL_W-1:0] odt_d,
  output logic [CA_W-1:0]   ca_q,
  output logic [NCS-1:0]    cs_q_n,
  output logic [CTRL_W-1:0] cke_q,
  output logic [CTRL_W-1:0] odt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca_q   <= '0;
      cs_q_n <= '1;
    end else if (sel_one) begin
      ca_q   <= ca_d;
      cs_q_n <= cs_fan_n;
    end else begin
      cs_q_n <= '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q <= '0;
      odt_q <= '0;
    end else begin
      cke_q <= cke_d;
      odt_q <= odt_d;
    end
  end
endmodule

// File: rtl/rcd_parity_err.sv
module rcd_parity_err #(
  parameter int CA_W    = 22,
  parameter int ERR_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_one,
  input  logic [CA_W-1:0] ca_d,
  input  logic            par_d,
  output logic            err_n
);
  localparam int CW = $clog2(ERR_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(ERR_CYC);

  logic          bad_q;
  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bad_q    <= 1'b0;
      hold_cnt <= '0;
    end else begin
      bad_q <= sel_one & (^{ca_d, par_d});
      if (bad_q)              hold_cnt <= LOAD;
      else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
    end
  end

  assign err_n = (hold_cnt == 0);
endmodule

// File: rtl/rcd_oe_ctrl.sv
module rcd_oe_ctrl
  import rcd_pkg::*;
#(
  parameter int CA_W   = 22,
  parameter int CTRL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [OE_W-1:0]   cfg_wdata,
  input  logic [CA_W-1:0]   ca_q,
  input  logic [CTRL_W-1:0] cke_q,
  input  logic [CTRL_W-1:0] odt_q,
  output logic [CA_W-1:0]   ca_a,
  output logic [CA_W-1:0]   ca_b,
  output logic [CTRL_W-1:0] cke_a,
  output logic [CTRL_W-1:0] cke_b,
  output logic [CTRL_W-1:0] odt_a,
  output logic [CTRL_W-1:0] odt_b,
  output logic [OE_W-1:0]   oe_bits
);
  localparam int NSIDE = 2;

  logic [OE_W-1:0]   oe_q;
  logic [CA_W-1:0]   ca_side  [NSIDE];
  logic [CTRL_W-1:0] cke_side [NSIDE];
  logic [CTRL_W-1:0] odt_side [NSIDE];

  always_ff @(posedge clk) begin
    if (!rst_n)      oe_q <= '1;
    else if (cfg_we) oe_q <= cfg_wdata;
  end

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    localparam int CA_BIT = (s == 0) ? OE_CA_A : OE_CA_B;
    localparam int CT_BIT = (s == 0) ? OE_CT_A : OE_CT_B;
    assign ca_side[s]  = oe_q[CA_BIT] ? ca_q  : '0;
    assign cke_side[s] = oe_q[CT_BIT] ? cke_q : '0;
    assign odt_side[s] = oe_q[CT_BIT] ? odt_q : '0;
  end

  assign ca_a    = ca_side[0];
  assign ca_b    = ca_side[1];
  assign cke_a   = cke_side[0];
  assign cke_b   = cke_side[1];
  assign odt_a   = odt_side[0];
  assign odt_b   = odt_side[1];
  assign oe_bits = oe_q;
endmodule

// File: rtl/rcd_ca_register.sv
module rcd_ca_register
  import rcd_pkg::*;
#(
  parameter int CA_W    = 22,
  parameter int CTRL_W  = 2,
  parameter int ERR_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              quad_sel_n,
  input  logic [3:0]        cs_n_i,
  input  logic [CA_W-1:0]   ca_i,
  input  logic [CTRL_W-1:0] cke_i,
  input  logic [CTRL_W-1:0] odt_i,
  input  logic              par_i,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_wdata,
  output logic [CA_W-1:0]   qa_ca_o,
  output logic [CA_W-1:0]   qb_ca_o,
  output logic [3:0]        qcs_n_o,
  output logic [CTRL_W-1:0] qa_cke_o,
  output logic [CTRL_W-1:0] qb_cke_o,
  output logic [CTRL_W-1:0] qa_odt_o,
  output logic [CTRL_W-1:0] qb_odt_o,
  output logic              err_n_o
);
  logic              sel_one;
  logic [NCS-1:0]    cs_fan_n;
  logic [CA_W-1:0]   ca_q;
  logic [CTRL_W-1:0] cke_q;
  logic [CTRL_W-1:0] odt_q;
  logic [OE_W-1:0]   oe_bits;

  rcd_cs_qual u_qual (
    .mode_dual (quad_sel_n),
    .cs_n      (cs_n_i),
    .sel_one   (sel_one),
    .cs_fan_n  (cs_fan_n)
  );

  rcd_capture #(.CA_W(CA_W), .CTRL_W(CTRL_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_one  (sel_one),
    .cs_fan_n (cs_fan_n),
    .ca_d     (ca_i),
    .cke_d    (cke_i),
    .odt_d    (odt_i),
    .ca_q     (ca_q),
    .cs_q_n   (qcs_n_o),
    .cke_q    (cke_q),
    .odt_q    (odt_q)
  );

  rcd_parity_err #(.CA_W(CA_W), .ERR_CYC(ERR_CYC)) u_par (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_one (sel_one),
    .ca_d    (ca_i),
    .par_d   (par_i),
    .err_n   (err_n_o)
  );

  rcd_oe_ctrl #(.CA_W(CA_W), .CTRL_W(CTRL_W)) u_oe (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .ca_q      (ca_q),
    .cke_q     (cke_q),
    .odt_q     (odt_q),
    .ca_a      (qa_ca_o),
    .ca_b      (qb_ca_o),
    .cke_a     (qa_cke_o),
    .cke_b     (qb_cke_o),
    .odt_a     (qa_odt_o),
    .odt_b     (qb_odt_o),
    .oe_bits   (oe_bits)
  );
endmodule

// File: rtl/rcd_ca_register_chk.sv
module rcd_ca_register_chk #(
  parameter int CA_W   = 22,
  parameter int CTRL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              quad_sel_n,
  input logic [3:0]        cs_n_i,
  input logic [CTRL_W-1:0] cke_i,
  input logic [CTRL_W-1:0] odt_i,
  input logic [CA_W-1:0]   qa_ca_o,
  input logic [3:0]        qcs_n_o,
  input logic [CTRL_W-1:0] qa_cke_o,
  input logic [CTRL_W-1:0] qb_cke_o,
  input logic [CTRL_W-1:0] qa_odt_o,
  input logic              err_n_o,
  input logic [3:0]        oe_bits
);
  logic [3:0] seen_n;
  logic       one_sel;

  always_comb begin
    seen_n  = quad_sel_n ? {2'b11, cs_n_i[1:0]} : cs_n_i;
    one_sel = ($countones(~seen_n) == 1);
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (qcs_n_o == 4'hF && qa_cke_o == '0 && qb_cke_o == '0 && err_n_o)); // R8

  AST_BADSEL_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(one_sel)) |-> qcs_n_o == 4'hF); // R4

  AST_BADSEL_CA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(one_sel) && oe_bits[0] && $past(oe_bits[0])) |-> $stable(qa_ca_o)); // R4

  AST_QUAD_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(one_sel) && !$past(quad_sel_n)) |-> qcs_n_o == $past(cs_n_i)); // R3

  AST_DUAL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(one_sel) && $past(quad_sel_n)) |-> qcs_n_o == {2{$past(cs_n_i[1:0])}}); // R2

  AST_CTRL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && oe_bits[2]) |-> (qa_cke_o == $past(cke_i) && qa_odt_o == $past(odt_i))); // R5

  AST_ERR_TWO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(err_n_o)) |=> !err_n_o); // R7
endmodule

bind rcd_ca_register rcd_ca_register_chk #(.CA_W(CA_W), .CTRL_W(CTRL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .quad_sel_n (quad_sel_n),
  .cs_n_i     (cs_n_i),
  .cke_i      (cke_i),
  .odt_i      (odt_i),
  .qa_ca_o    (qa_ca_o),
  .qcs_n_o    (qcs_n_o),
  .qa_cke_o   (qa_cke_o),
  .qb_cke_o   (qb_cke_o),
  .qa_odt_o   (qa_odt_o),
  .err_n_o    (err_n_o),
  .oe_bits    (oe_bits)
);

// File: tb/tb_rcd_ca_register.sv
module tb_rcd_ca_register;
  localparam int CA_W   = 12;
  localparam int CTRL_W = 2;

  typedef struct {
    logic [CA_W-1:0]   ca_a;
    logic [CA_W-1:0]   ca_b;
    logic [3:0]        cs;
    logic [CTRL_W-1:0] cke_a;
    logic [CTRL_W-1:0] cke_b;
    logic [CTRL_W-1:0] odt_a;
    logic [CTRL_W-1:0] odt_b;
    logic              err_n;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              quad_sel_n = 1'b1;
  logic [3:0]        cs_n_i = 4'hF;
  logic [CA_W-1:0]   ca_i = '0;
  logic [CTRL_W-1:0] cke_i = '0;
  logic [CTRL_W-1:0] odt_i = '0;
  logic              par_i = 1'b0;
  logic              cfg_we = 1'b0;
  logic [3:0]        cfg_wdata = 4'hF;
  logic [CA_W-1:0]   qa_ca_o, qb_ca_o;
  logic [3:0]        qcs_n_o;
  logic [CTRL_W-1:0] qa_cke_o, qb_cke_o, qa_odt_o, qb_odt_o;
  logic              err_n_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  // reference state, built from the requirements
  logic [CA_W-1:0]   m_ca = '0;
  logic [3:0]        m_cs = 4'hF;
  logic [CTRL_W-1:0] m_cke = '0, m_odt = '0;
  logic [3:0]        m_oe = 4'hF;
  int                m_cnt = 0;
  bit                m_pend = 0;

  always #10 clk = ~clk;

  rcd_ca_register #(.CA_W(CA_W), .CTRL_W(CTRL_W), .ERR_CYC(2)) dut (
    .clk(clk), .rst_n(rst_n), .quad_sel_n(quad_sel_n), .cs_n_i(cs_n_i),
    .ca_i(ca_i), .cke_i(cke_i), .odt_i(odt_i), .par_i(par_i),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .qa_ca_o(qa_ca_o), .qb_ca_o(qb_ca_o), .qcs_n_o(qcs_n_o),
    .qa_cke_o(qa_cke_o), .qb_cke_o(qb_cke_o),
    .qa_odt_o(qa_odt_o), .qb_odt_o(qb_odt_o), .err_n_o(err_n_o)
  );

  task automatic drive(input bit rst, input bit qn, input logic [3:0] cs,
                       input logic [CA_W-1:0] ca, input bit par_ok,
                       input bit we, input logic [3:0] wd, input string tag);
    exp_t e;
    logic [3:0] seen;
    bit one;
    logic [CTRL_W-1:0] ck, od;
    @(negedge clk);
    ck = CTRL_W'($urandom);
    od = CTRL_W'($urandom);
    rst_n = !rst; quad_sel_n = qn; cs_n_i = cs; ca_i = ca;
    par_i = par_ok ? ^ca : ~^ca;
    cke_i = ck; odt_i = od; cfg_we = we; cfg_wdata = wd;
    if (rst) begin
      m_ca = '0; m_cs = 4'hF; m_cke = '0; m_odt = '0; m_oe = 4'hF;
      m_cnt = 0; m_pend = 0;
    end else begin
      seen = qn ? {2'b11, cs[1:0]} : cs;
      one = ($countones(~seen) == 1);
      if (m_pend) m_cnt = 2;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_pend = one && !par_ok;
      if (one) begin
        m_ca = ca;
        m_cs = qn ? {cs[1:0], cs[1:0]} : cs;
      end else m_cs = 4'hF;
      m_cke = ck; m_odt = od;
      if (we) m_oe = wd;
    end
    e.ca_a  = m_oe[0] ? m_ca : '0;
    e.ca_b  = m_oe[1] ? m_ca : '0;
    e.cke_a = m_oe[2] ? m_cke : '0;
    e.odt_a = m_oe[2] ? m_odt : '0;
    e.cke_b = m_oe[3] ? m_cke : '0;
    e.odt_b = m_oe[3] ? m_odt : '0;
    e.cs    = m_cs;
    e.err_n = (m_cnt == 0);
    e.tag   = tag;
    q.push_back(e);
  endtask

  // monitor: sample 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({qa_ca_o, qb_ca_o, qcs_n_o, qa_cke_o, qb_cke_o, qa_odt_o, qb_odt_o, err_n_o} !==
            {e.ca_a, e.ca_b, e.cs, e.cke_a, e.cke_b, e.odt_a, e.odt_b, e.err_n}) begin
          errors++;
          $display("FAIL %s: act ca=%h/%h cs=%b cke=%b/%b odt=%b/%b err_n=%b exp ca=%h/%h cs=%b cke=%b/%b odt=%b/%b err_n=%b",
                   e.tag, qa_ca_o, qb_ca_o, qcs_n_o, qa_cke_o, qb_cke_o, qa_odt_o, qb_odt_o, err_n_o,
                   e.ca_a, e.ca_b, e.cs, e.cke_a, e.cke_b, e.odt_a, e.odt_b, e.err_n);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: act hung exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    drive(1, 1, 4'h0, 12'hABC, 1, 0, 4'h0, "R8");
    drive(1, 1, 4'hE, 12'h123, 1, 1, 4'h0, "R8");
    // R1 / R2 dual mode, select 0 then select 1
    drive(0, 1, 4'hE, 12'h5A5, 1, 0, 4'h0, "R1");
    drive(0, 1, 4'h1, 12'h3C3, 1, 0, 4'h0, "R2");
    drive(0, 1, 4'h2, 12'h0F0, 1, 0, 4'h0, "R2");
    // R4 both / none selected: hold
    drive(0, 1, 4'hC, 12'hFFF, 1, 0, 4'h0, "R4");
    drive(0, 1, 4'hF, 12'h001, 1, 0, 4'h0, "R4");
    // R3 quad mode
    drive(0, 0, 4'hB, 12'h777, 1, 0, 4'h0, "R3");
    drive(0, 0, 4'h7, 12'h888, 1, 0, 4'h0, "R3");
    drive(0, 0, 4'h3, 12'h999, 1, 0, 4'h0, "R4");
    drive(0, 0, 4'hE, 12'h246, 1, 0, 4'h0, "R3");
    // R5 ctrl bits with no select
    for (int i = 0; i < 4; i++) drive(0, 0, 4'hF, 12'h000, 1, 0, 4'h0, "R5");
    // R7 parity error, qualified, then idle window
    drive(0, 1, 4'hE, 12'h007, 0, 0, 4'h0, "R7");
    for (int i = 0; i < 4; i++) drive(0, 1, 4'hF, 12'h000, 1, 0, 4'h0, "R7");
    // R7 error unqualified: no flag
    drive(0, 1, 4'hC, 12'h001, 0, 0, 4'h0, "R7");
    for (int i = 0; i < 3; i++) drive(0, 1, 4'hF, 12'h000, 1, 0, 4'h0, "R7");
    // R7 back-to-back errors extend the window
    drive(0, 0, 4'hD, 12'h00B, 0, 0, 4'h0, "R7");
    drive(0, 0, 4'hB, 12'h00D, 0, 0, 4'h0, "R7");
    for (int i = 0; i < 4; i++) drive(0, 0, 4'hF, 12'h000, 1, 0, 4'h0, "R7");
    // R6 disable A side groups, selects still driven
    drive(0, 1, 4'hF, 12'h000, 1, 1, 4'b1010, "R6");
    drive(0, 1, 4'hD, 12'hACE, 1, 0, 4'h0, "R6");
    drive(0, 1, 4'hE, 12'h135, 1, 1, 4'b0101, "R6");
    drive(0, 0, 4'h7, 12'h9BD, 1, 0, 4'h0, "R6");
    drive(0, 0, 4'hF, 12'h000, 1, 1, 4'hF, "R6");
    // R8 reset in mid-run, reset ignores write
    drive(1, 0, 4'hE, 12'h111, 0, 1, 4'h0, "R8");
    drive(0, 0, 4'hF, 12'h000, 1, 0, 4'h0, "R8");
    // random traffic
    for (int i = 0; i < 300; i++)
      drive(0, 1'($urandom), 4'($urandom), CA_W'($urandom), ($urandom % 4) != 0,
            ($urandom % 16) == 0, 4'($urandom), "R4");
    drive(0, 1, 4'hF, 12'h000, 1, 0, 4'h0, "R4");
    wait (q.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule